// File: doc/BRIEF.md
# DMA Request Arbiter with Status

This block is the request side of a multi-channel DMA controller (four channels by default). Each channel has two request sources: a hardware request line and a request bit that software sets or clears with a register write. A per-channel mask bit blocks both sources. The unmasked requests feed a priority picker, which chooses one channel.

The picker uses either fixed order or rotating order. Fixed order favours the lowest channel index. Rotating order moves the channel that was last serviced to the back of the line. While no channel is granted, the picker's choice is registered as the grant. The grant stays fixed until the transfer engine reports that service has ended.

The transfer engine also reports terminal-count and external end-of-process events for the granted channel. These events clear that channel's software request bit. A terminal-count event also sets the channel's flag in a status register. Reading the status register clears these flags. A master clear input puts the block back to its reset state, in which every mask bit is set.

Top module: `dma_req_arbiter`

## Requirements
- R1: Channel c is pending when (hardware request c OR software request bit c) AND NOT mask bit c. Reading status (read address 0) returns the pending vector in bits [7:4] and the terminal-count flags in bits [3:0].
- R2: A write to address 1 sets the software request bit of the channel in data[1:0] to the value in data[2]. Read address 1 returns the request bits in bits [3:0].
- R3: A terminal-count pulse or an external end-of-process pulse during a grant clears the granted channel's software request bit. This takes effect on the same clock edge.
- R4: A terminal-count pulse during a grant sets the granted channel's status flag. A read of status returns the flags as they were before the read, then clears them. A terminal-count pulse in the same cycle as the read wins over the clear.
- R5: Synchronous reset clears the command bit, the request bits, the status flags, the grant and rd_data, and sets all mask bits.
- R6: master_clr has the same effect as reset.
- R7: A write to address 0 sets the priority mode from data[0] (0 = fixed, 1 = rotating). In fixed mode the lowest-indexed pending channel wins.
- R8: In rotating mode the search starts one channel after the last serviced channel and wraps around. After reset the last serviced channel counts as channel 3, so the search starts at channel 0.
- R9: A masked channel never wins, whether its request comes from hardware or from software.
- R10: While idle with any channel pending, grant_vld and grant_ch are set on the next clock edge. While granted, neither changes until svc_done. svc_done clears grant_vld on the next edge.
- R11: A write to address 2 sets the mask bit of channel data[1:0] to the value in data[2]. A write to address 3 loads all mask bits from data[3:0].
- R12: rd_data is registered: it shows the register selected by rd_addr one clock after rd_en. Read address 2 returns the mask and read address 3 returns the command bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_clr | input | 1 | Software master clear, same effect as reset |
| dreq | input | 4 | Hardware request lines, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| tc_pulse | input | 1 | Terminal count reached on the granted channel |
| eop_pulse | input | 1 | External end of process on the granted channel |
| svc_done | input | 1 | Service of the granted channel has ended |
| grant_vld | output | 1 | A channel is granted |
| grant_ch | output | 2 | Index of the granted channel |

## Verification
The assertions check four rules on every cycle:
- the picker's winner is always a pending, unmasked channel;
- in fixed mode, no lower-indexed channel is pending when the winner is chosen;
- a grant holds its channel until svc_done;
- a master clear leaves all masks set and the request bits and flags cleared.

The bench's scenarios are needed to show the rest. These are the rotation order across successive services, the clear-on-read of the terminal-count flags, the clearing of software requests by terminal-count and end-of-process events, and the exact read data for each address.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam logic [1:0] WA_CMD     = 2'd0;
  localparam logic [1:0] WA_REQ     = 2'd1;
  localparam logic [1:0] WA_MASK1   = 2'd2;
  localparam logic [1:0] WA_MASKALL = 2'd3;
  localparam logic [1:0] RA_STATUS  = 2'd0;
  localparam logic [1:0] RA_REQ     = 2'd1;
  localparam logic [1:0] RA_MASK    = 2'd2;
  localparam logic [1:0] RA_CMD     = 2'd3;
endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH),
  parameter int DW  = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           master_clr,
  input  logic [NCH-1:0] dreq,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [1:0]     rd_addr,
  input  logic           gnt_vld,
  input  logic [CW-1:0]  gnt_ch,
  input  logic           tc_pulse,
  input  logic           eop_pulse,
  output logic [NCH-1:0] pend,
  output logic           rot_q,
  output logic [DW-1:0]  rd_data
);
  logic [NCH-1:0] req_q, mask_q, tc_q;
  logic [DW-1:0]  rd_mux;
  logic           clr;

  assign clr  = rst | master_clr;
  assign pend = (dreq | req_q) & ~mask_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, hit;
    assign sel = (wr_data[CW-1:0] == CW'(c));
    assign hit = gnt_vld && (gnt_ch == CW'(c));
    always_ff @(posedge clk) begin
      if (clr) begin
        req_q[c]  <= 1'b0;
        mask_q[c] <= 1'b1;
        tc_q[c]   <= 1'b0;
      end else begin
        if (wr_en && wr_addr == WA_REQ && sel) req_q[c] <= wr_data[CW];
        if ((tc_pulse || eop_pulse) && hit)    req_q[c] <= 1'b0;
        if (wr_en && wr_addr == WA_MASK1 && sel) mask_q[c] <= wr_data[CW];
        if (wr_en && wr_addr == WA_MASKALL)      mask_q[c] <= wr_data[c];
        if (rd_en && rd_addr == RA_STATUS) tc_q[c] <= 1'b0;
        if (tc_pulse && hit)               tc_q[c] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      RA_STATUS: rd_mux = {pend, tc_q};
      RA_REQ:    rd_mux = DW'(req_q);
      RA_MASK:   rd_mux = DW'(mask_q);
      default:   rd_mux = DW'(rot_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rot_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == WA_CMD) rot_q <= wr_data[0];
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_mclr_state_R6: assert property (@(posedge clk) disable iff (rst)
    master_clr |=> (&mask_q) && (req_q == '0) && (tc_q == '0) && !rot_q);
endmodule

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] cand,
  input  logic           rotate,
  input  logic [CW-1:0]  last_ch,
  output logic           win_any,
  output logic [CW-1:0]  win_ch
);
  logic [CW-1:0] base;
  logic [CW-1:0] idx;

  always_comb begin
    base    = rotate ? last_ch + CW'(1) : '0;
    win_any = 1'b0;
    win_ch  = '0;
    idx     = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = base + CW'(i);
      if (!win_any && cand[idx]) begin
        win_any = 1'b1;
        win_ch  = idx;
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH),
  parameter int DW  = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           master_clr,
  input  logic [NCH-1:0] dreq,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [1:0]     rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           tc_pulse,
  input  logic           eop_pulse,
  input  logic           svc_done,
  output logic           grant_vld,
  output logic [CW-1:0]  grant_ch
);
  logic [NCH-1:0] pend;
  logic           rot_q, win_any;
  logic [CW-1:0]  win_ch, last_q;
  logic [NCH-1:0] below_win;

  dma_arb_regs #(.NCH(NCH), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .master_clr(master_clr), .dreq(dreq),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .gnt_vld(grant_vld), .gnt_ch(grant_ch),
    .tc_pulse(tc_pulse), .eop_pulse(eop_pulse),
    .pend(pend), .rot_q(rot_q), .rd_data(rd_data)
  );

  dma_arb_prio #(.NCH(NCH), .CW(CW)) u_prio (
    .cand(pend), .rotate(rot_q), .last_ch(last_q),
    .win_any(win_any), .win_ch(win_ch)
  );

  always_ff @(posedge clk) begin
    if (rst || master_clr) begin
      grant_vld <= 1'b0;
      grant_ch  <= '0;
      last_q    <= CW'(NCH - 1);
    end else if (grant_vld) begin
      if (svc_done) begin
        grant_vld <= 1'b0;
        last_q    <= grant_ch;
      end
    end else if (win_any) begin
      grant_vld <= 1'b1;
      grant_ch  <= win_ch;
    end
  end

  assign below_win = (NCH'(1) << win_ch) - NCH'(1);

  assert_winner_unmasked_R9: assert property (@(posedge clk) disable iff (rst)
    win_any |-> pend[win_ch]);
  assert_fixed_lowest_R7: assert property (@(posedge clk) disable iff (rst)
    (win_any && !rot_q) |-> ((pend & below_win) == '0));
  assert_grant_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !svc_done && !master_clr) |=> grant_vld && $stable(grant_ch));
  assert_idle_grants_R10: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && win_any && !master_clr) |=> grant_vld);
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  logic clk = 0, rst = 1, master_clr = 0;
  logic [3:0] dreq = 0;
  logic wr_en = 0, rd_en = 0, tc_pulse = 0, eop_pulse = 0, svc_done = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic grant_vld;
  logic [1:0] grant_ch;
  int checks = 0, errors = 0;
  string tag = "R5";

  always #2.5 clk = ~clk;

  dma_req_arbiter u0 (.clk(clk), .rst(rst), .master_clr(master_clr), .dreq(dreq),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .tc_pulse(tc_pulse),
    .eop_pulse(eop_pulse), .svc_done(svc_done), .grant_vld(grant_vld),
    .grant_ch(grant_ch));

  // behavioural reference
  bit m_rot, m_gv;
  bit m_req[4], m_mask[4], m_tc[4];
  int m_gc, m_last = 3;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit p[4];
    bit n_req[4], n_mask[4], n_tc[4];
    int wch;
    if (rst || master_clr) begin
      m_rot = 0; m_gv = 0; m_gc = 0; m_last = 3; m_rd = 0;
      foreach (m_req[i]) begin m_req[i] = 0; m_mask[i] = 1; m_tc[i] = 0; end
    end else begin
      foreach (p[i]) p[i] = (dreq[i] | m_req[i]) & ~m_mask[i];
      if (rd_en) begin
        m_rd = 0;
        for (int i = 0; i < 4; i++) begin
          case (rd_addr)
            0: begin m_rd[i+4] = p[i]; m_rd[i] = m_tc[i]; end
            1: m_rd[i] = m_req[i];
            2: m_rd[i] = m_mask[i];
            default: m_rd[0] = m_rot;
          endcase
        end
      end
      n_req = m_req; n_mask = m_mask; n_tc = m_tc;
      if (wr_en && wr_addr == 1) n_req[wr_data[1:0]] = wr_data[2];
      if (wr_en && wr_addr == 2) n_mask[wr_data[1:0]] = wr_data[2];
      if (wr_en && wr_addr == 3) foreach (n_mask[i]) n_mask[i] = wr_data[i];
      if (m_gv && (tc_pulse || eop_pulse)) n_req[m_gc] = 0;
      if (rd_en && rd_addr == 0) foreach (n_tc[i]) n_tc[i] = 0;
      if (m_gv && tc_pulse) n_tc[m_gc] = 1;
      if (m_gv) begin
        if (svc_done) begin m_gv = 0; m_last = m_gc; end
      end else begin
        wch = -1;
        for (int i = 0; i < 4; i++) begin
          int c;
          c = ((m_rot ? m_last + 1 : 0) + i) % 4;
          if (wch < 0 && p[c]) wch = c;
        end
        if (wch >= 0) begin m_gv = 1; m_gc = wch; end
      end
      if (wr_en && wr_addr == 0) m_rot = wr_data[0];
      m_req = n_req; m_mask = n_mask; m_tc = n_tc;
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk(grant_vld == m_gv, {tag, " grant_vld"}, grant_vld, m_gv);
    if (m_gv) chk(grant_ch == m_gc, {tag, " grant_ch"}, grant_ch, m_gc);
    chk(rd_data == m_rd, {tag, " rd_data"}, rd_data, m_rd);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic done();
    svc_done = 1; @(negedge clk); svc_done = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R5 reset state
    chk(grant_vld == 0, "R5 grant", grant_vld, 0);
    rd(2); chk(rd_data == 8'h0F, "R5 mask set", rd_data, 8'h0F);
    rd(0); chk(rd_data == 8'h00, "R5 status", rd_data, 0);
    // R7 fixed priority, R10 hold
    tag = "R7";
    wr(3, 8'h00);
    dreq = 4'b1010; idle(1);
    chk(grant_vld && grant_ch == 1, "R7 lowest wins", grant_ch, 1);
    tag = "R10";
    dreq = 4'b1011; idle(2);
    chk(grant_ch == 1, "R10 hold", grant_ch, 1);
    done(); chk(grant_vld == 0, "R10 release", grant_vld, 0);
    idle(1); chk(grant_ch == 0, "R10 regrant", grant_ch, 0);
    dreq = 0; done(); idle(1);
    // R2 software request, R3/R4 terminal count
    tag = "R2";
    wr(1, 8'h06); idle(1);
    chk(grant_vld && grant_ch == 2, "R2 sw request", grant_ch, 2);
    tag = "R4";
    tc_pulse = 1; @(negedge clk); tc_pulse = 0;
    rd(1); chk(rd_data == 8'h00, "R3 req cleared by tc", rd_data, 0);
    rd(0); chk(rd_data == 8'h04, "R4 tc flag", rd_data, 8'h04);
    rd(0); chk(rd_data == 8'h00, "R4 clear on read", rd_data, 0);
    done(); idle(1);
    // R3 external end of process
    tag = "R3";
    wr(1, 8'h07); idle(1);
    chk(grant_ch == 3, "R3 granted ch3", grant_ch, 3);
    eop_pulse = 1; @(negedge clk); eop_pulse = 0;
    rd(1); chk(rd_data == 8'h00, "R3 req cleared by eop", rd_data, 0);
    rd(0); chk(rd_data == 8'h00, "R3 no tc flag", rd_data, 0);
    done(); idle(1);
    // R11 single mask, R9 masked never wins, R1 pending
    tag = "R9";
    wr(2, 8'h04); dreq = 4'b0001; idle(3);
    chk(grant_vld == 0, "R9 masked hw", grant_vld, 0);
    wr(1, 8'h04); idle(2);
    chk(grant_vld == 0, "R9 masked sw", grant_vld, 0);
    tag = "R1";
    rd(0); chk(rd_data == 8'h00, "R1 masked not pending", rd_data, 0);
    tag = "R11";
    wr(2, 8'h00); idle(1);
    chk(grant_vld && grant_ch == 0, "R11 unmask", grant_ch, 0);
    rd(0); chk(rd_data == 8'h10, "R1 pending bit", rd_data, 8'h10);
    dreq = 0; wr(1, 8'h00); done(); idle(1);
    // R8 rotating priority, R12 command readback
    tag = "R8";
    wr(0, 8'h01);
    rd(3); chk(rd_data == 8'h01, "R12 cmd read", rd_data, 1);
    dreq = 4'b1111;
    for (int k = 0; k < 4; k++) begin
      idle(1);
      chk(grant_ch == 2'((k + 1) % 4), "R8 rotation", grant_ch, (k + 1) % 4);
      done();
    end
    // R6 master clear
    tag = "R6";
    master_clr = 1; @(negedge clk); master_clr = 0;
    idle(2); chk(grant_vld == 0, "R6 grant cleared", grant_vld, 0);
    rd(2); chk(rd_data == 8'h0F, "R6 mask set", rd_data, 8'h0F);
    rd(3); chk(rd_data == 8'h00, "R6 cmd cleared", rd_data, 0);
    rd(0); chk(rd_data == 8'h00, "R6 status", rd_data, 0);
    dreq = 0; idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule